// File: doc/BRIEF.md
# Byte Rotate, Shift and Bit-Manipulation Unit

This block is a purely combinational datapath slice. It takes one byte and performs one of three kinds of work on it. The first is a rotate or shift of eight possible kinds. The second tests a single bit. The third forces a single bit to one or to zero. It returns the new byte, the write strobes and an updated flag byte. It sits between an instruction decoder and the register file and memory write port, and does no decoding or memory access of its own.

The operation class decides what is produced. A shift rewrites the byte and loads carry with the bit that leaves it. A bit test only touches flags. A bit force rewrites the byte and leaves every flag unchanged. An accumulator mode gives the short-form rotates, which update only carry. A load-also input makes every byte-writing result appear on the register write path as well as the memory write path, in the same cycle.

Top module: `rotshift_bit_unit`

Flag byte layout, used on both `flags_in` and `flags_out`:
- bit 7 sign
- bit 6 zero
- bit 4 half-carry
- bit 2 parity/overflow
- bit 1 subtract
- bit 0 carry

Bits 5 and 3 are spare.

Operation class encoding (`op_class`):
- 00 shift
- 01 bit test
- 10 bit reset
- 11 bit set

## Requirements
- R1: With `op_class`=00, `shift_op`=000 rotates left circularly and `shift_op`=001 rotates right circularly. The bit that leaves the byte enters at the opposite end and is also copied into carry (flag bit 0).
- R2: `shift_op`=010 rotates left through carry and `shift_op`=011 rotates right through carry. The entering bit is `carry_in`, and the leaving bit becomes the new carry.
- R3: `shift_op`=100 shifts left and inserts 0 at bit 0. `shift_op`=101 shifts right and keeps bit 7. `shift_op`=110 shifts left and inserts 1 at bit 0. `shift_op`=111 shifts right and inserts 0 at bit 7, so in full mode its sign flag is always 0. Each of these loads carry with the leaving bit.
- R4: For a shift with `acc_mode`=0, sign is set to result bit 7 and zero is set when the result is 0. Parity/overflow is set when the result has an even number of ones. Half-carry and subtract are cleared.
- R5: For a shift with `acc_mode`=1, only carry takes the leaving bit. Half-carry and subtract are cleared, and sign, zero and parity/overflow keep their `flags_in` values.
- R6: A bit test (`op_class`=01) sets zero to the inverse of data bit `bit_sel`, sets half-carry and clears subtract. Sign, parity/overflow and carry keep their `flags_in` values, `data_out` equals `data_in`, and neither write strobe is raised.
- R7: A bit reset (10) or bit set (11) forces data bit `bit_sel` to 0 or 1, leaves every other data bit unchanged and passes `flags_in` to `flags_out` unchanged.
- R8: `mem_we` is 1 for classes 00, 10 and 11 and 0 for class 01. `reg_we` is 1 exactly when `mem_we` is 1 and `load_also` is 1, and the same byte is on `data_out` for both paths.
- R9: Flag bits 5 and 3 pass from `flags_in` to `flags_out` unchanged in every class and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 8 | Byte operated on |
| carry_in | input | 1 | Bit entering a rotate through carry |
| flags_in | input | 8 | Current flag byte |
| shift_op | input | 3 | Shift kind, used when class is 00 |
| bit_sel | input | 3 | Bit index for test, reset and set |
| op_class | input | 2 | 00 shift, 01 test, 10 reset, 11 set |
| acc_mode | input | 1 | Short-form rotate: only carry updated |
| load_also | input | 1 | Also write the result to the register path |
| data_out | output | 8 | Resulting byte |
| mem_we | output | 1 | Memory path write strobe |
| reg_we | output | 1 | Register path write strobe |
| flags_out | output | 8 | Updated flag byte |

## Verification
The bench builds the unit with its default byte width of 8, so all 256 data values can be driven through every shift kind. Each shift kind is run with both carry inputs and in both flag modes. All eight bit indices are driven for test, set and reset. The flag input varies from vector to vector, which shows whether any preserved field leaks or any cleared field survives. With a width of 8, parity and the edge bits that carry enters and leaves are exercised at their true positions.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_RESET = 2'b10,
        CLS_SET   = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        SH_ROTL_CIRC = 3'b000,
        SH_ROTR_CIRC = 3'b001,
        SH_ROTL_CARRY = 3'b010,
        SH_ROTR_CARRY = 3'b011,
        SH_SHL_ZERO  = 3'b100,
        SH_SHR_ARITH = 3'b101,
        SH_SHL_ONE   = 3'b110,
        SH_SHR_LOGIC = 3'b111
    } shift_op_e;

    localparam int FL_SIGN   = 7;
    localparam int FL_ZERO   = 6;
    localparam int FL_HALF   = 4;
    localparam int FL_PARITY = 2;
    localparam int FL_SUB    = 1;
    localparam int FL_CARRY  = 0;

endpackage

// File: rtl/rsb_shift_core.sv
module rsb_shift_core
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] dout,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        case (shift_op_e'(op))
            SH_ROTL_CIRC: begin
                dout = {din[MSB-1:0], din[MSB]};
                cout = din[MSB];
            end
            SH_ROTR_CIRC: begin
                dout = {din[0], din[MSB:1]};
                cout = din[0];
            end
            SH_ROTL_CARRY: begin
                dout = {din[MSB-1:0], cin};
                cout = din[MSB];
            end
            SH_ROTR_CARRY: begin
                dout = {cin, din[MSB:1]};
                cout = din[0];
            end
            SH_SHL_ZERO: begin
                dout = {din[MSB-1:0], 1'b0};
                cout = din[MSB];
            end
            SH_SHR_ARITH: begin
                dout = {din[MSB], din[MSB:1]};
                cout = din[0];
            end
            SH_SHL_ONE: begin
                dout = {din[MSB-1:0], 1'b1};
                cout = din[MSB];
            end
            default: begin
                dout = {1'b0, din[MSB:1]};
                cout = din[0];
            end
        endcase
    end
endmodule

// File: rtl/rsb_bit_modify.sv
module rsb_bit_modify #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  sel,
    input  logic              force_one,
    output logic [DATA_W-1:0] dout,
    output logic              tested
);
    logic [DATA_W-1:0] mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (sel == IDX_W'(i));
    end

    assign tested = |(din & mask);
    assign dout   = force_one ? (din | mask) : (din & ~mask);
endmodule

// File: rtl/rsb_flag_merge.sv
module rsb_flag_merge
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        op_class,
    input  logic              acc_mode,
    input  logic [7:0]        flags_in,
    input  logic [DATA_W-1:0] shift_res,
    input  logic              shift_cout,
    input  logic              tested,
    output logic [7:0]        flags_out
);
    logic even_ones;
    assign even_ones = ~(^shift_res);

    always_comb begin
        flags_out = flags_in;
        unique case (op_class_e'(op_class))
            CLS_SHIFT: begin
                flags_out[FL_CARRY] = shift_cout;
                flags_out[FL_HALF]  = 1'b0;
                flags_out[FL_SUB]   = 1'b0;
                if (!acc_mode) begin
                    flags_out[FL_SIGN]   = shift_res[DATA_W-1];
                    flags_out[FL_ZERO]   = (shift_res == '0);
                    flags_out[FL_PARITY] = even_ones;
                end
            end
            CLS_TEST: begin
                flags_out[FL_ZERO] = ~tested;
                flags_out[FL_HALF] = 1'b1;
                flags_out[FL_SUB]  = 1'b0;
            end
            default: flags_out = flags_in;
        endcase
    end
endmodule

// File: rtl/rotshift_bit_unit.sv
module rotshift_bit_unit
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic              carry_in,
    input  logic [7:0]        flags_in,
    input  logic [2:0]        shift_op,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [1:0]        op_class,
    input  logic              acc_mode,
    input  logic              load_also,
    output logic [DATA_W-1:0] data_out,
    output logic              mem_we,
    output logic              reg_we,
    output logic [7:0]        flags_out
);
    logic [DATA_W-1:0] shift_res;
    logic              shift_cout;
    logic [DATA_W-1:0] bit_res;
    logic              tested;

    rsb_shift_core #(.DATA_W(DATA_W)) u_shift (
        .din  (data_in),
        .cin  (carry_in),
        .op   (shift_op),
        .dout (shift_res),
        .cout (shift_cout)
    );

    rsb_bit_modify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
        .din       (data_in),
        .sel       (bit_sel),
        .force_one (op_class[0]),
        .dout      (bit_res),
        .tested    (tested)
    );

    rsb_flag_merge #(.DATA_W(DATA_W)) u_flags (
        .op_class   (op_class),
        .acc_mode   (acc_mode),
        .flags_in   (flags_in),
        .shift_res  (shift_res),
        .shift_cout (shift_cout),
        .tested     (tested),
        .flags_out  (flags_out)
    );

    always_comb begin
        unique case (op_class_e'(op_class))
            CLS_SHIFT: data_out = shift_res;
            CLS_TEST:  data_out = data_in;
            default:   data_out = bit_res;
        endcase
    end

    assign mem_we = (op_class != CLS_TEST);
    assign reg_we = mem_we & load_also;
endmodule

// File: rtl/rotshift_bit_unit_chk.sv
module rotshift_bit_unit_chk #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] data_in,
    input logic [7:0]        flags_in,
    input logic [2:0]        shift_op,
    input logic [IDX_W-1:0]  bit_sel,
    input logic [1:0]        op_class,
    input logic              acc_mode,
    input logic [DATA_W-1:0] data_out,
    input logic              mem_we,
    input logic              reg_we,
    input logic [7:0]        flags_out
);
    logic known;
    assign known = !$isunknown({data_in, flags_in, shift_op, bit_sel, op_class, acc_mode});

    always_comb begin
        if (known) begin
            // R6
            test_nowrite_chk: assert (op_class != 2'b01 ||
                (!mem_we && !reg_we && data_out == data_in &&
                 flags_out[4] && !flags_out[1]));
            // R7
            force_flags_chk: assert (!op_class[1] ||
                (flags_out == flags_in && data_out[bit_sel] == op_class[0]));
            // R8
            reg_path_chk: assert (!reg_we || mem_we);
            // R3
            logic_shr_sign_chk: assert (!(op_class == 2'b00 && shift_op == 3'b111) ||
                (!data_out[DATA_W-1] && (acc_mode || !flags_out[7])));
            // R5
            acc_keep_chk: assert (!(op_class == 2'b00 && acc_mode) ||
                (flags_out[7:5] == flags_in[7:5] && flags_out[3:2] == flags_in[3:2] &&
                 flags_out[4:1] != 4'b1xx1 && !flags_out[4] && !flags_out[1]));
            // R9
            spare_bits_chk: assert (flags_out[5] == flags_in[5] && flags_out[3] == flags_in[3]);
        end
    end
endmodule

bind rotshift_bit_unit rotshift_bit_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .data_in   (data_in),
    .flags_in  (flags_in),
    .shift_op  (shift_op),
    .bit_sel   (bit_sel),
    .op_class  (op_class),
    .acc_mode  (acc_mode),
    .data_out  (data_out),
    .mem_we    (mem_we),
    .reg_we    (reg_we),
    .flags_out (flags_out)
);

// File: tb/rotshift_bit_unit_test.sv
module rotshift_bit_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [7:0] data_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] flags_in = '0;
    logic [2:0] shift_op = '0;
    logic [2:0] bit_sel = '0;
    logic [1:0] op_class = '0;
    logic       acc_mode = 1'b0;
    logic       load_also = 1'b0;
    logic [7:0] data_out;
    logic       mem_we;
    logic       reg_we;
    logic [7:0] flags_out;

    rotshift_bit_unit uut (
        .data_in(data_in), .carry_in(carry_in), .flags_in(flags_in),
        .shift_op(shift_op), .bit_sel(bit_sel), .op_class(op_class),
        .acc_mode(acc_mode), .load_also(load_also), .data_out(data_out),
        .mem_we(mem_we), .reg_we(reg_we), .flags_out(flags_out)
    );

    typedef struct {
        logic [7:0] d;
        logic [7:0] f;
        logic       mw;
        logic       rw;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic exp_t model(input logic [7:0] d, input logic ci, input logic [7:0] fi,
                                   input logic [2:0] op, input logic [2:0] b,
                                   input logic [1:0] cls, input logic am, input logic la);
        exp_t e;
        logic [7:0] r;
        logic co;
        e.f = fi;
        e.d = d;
        e.tag = "";
        if (cls == 2'b00) begin
            case (op)
                3'd0: begin r = {d[6:0], d[7]}; co = d[7]; e.tag = "R1"; end
                3'd1: begin r = {d[0], d[7:1]}; co = d[0]; e.tag = "R1"; end
                3'd2: begin r = {d[6:0], ci};   co = d[7]; e.tag = "R2"; end
                3'd3: begin r = {ci, d[7:1]};   co = d[0]; e.tag = "R2"; end
                3'd4: begin r = d << 1;         co = d[7]; e.tag = "R3"; end
                3'd5: begin r = {d[7], d[7:1]}; co = d[0]; e.tag = "R3"; end
                3'd6: begin r = (d << 1) | 8'h01; co = d[7]; e.tag = "R3"; end
                default: begin r = d >> 1;      co = d[0]; e.tag = "R3"; end
            endcase
            e.d = r;
            e.f[0] = co;
            e.f[4] = 1'b0;
            e.f[1] = 1'b0;
            if (!am) begin
                int ones = 0;
                for (int k = 0; k < 8; k++) ones += r[k];
                e.f[7] = r[7];
                e.f[6] = (r == 8'h00);
                e.f[2] = (ones % 2 == 0);
                e.tag = {e.tag, " R4"};
            end else begin
                e.tag = {e.tag, " R5"};
            end
        end else if (cls == 2'b01) begin
            e.f[6] = ~d[b];
            e.f[4] = 1'b1;
            e.f[1] = 1'b0;
            e.tag = "R6";
        end else begin
            e.d[b] = cls[0];
            e.tag = "R7";
        end
        e.mw = (cls != 2'b01);
        e.rw = e.mw && la;
        e.tag = {e.tag, " R8 R9"};
        return e;
    endfunction

    task automatic drive(input logic [7:0] d, input logic ci, input logic [7:0] fi,
                         input logic [2:0] op, input logic [2:0] b,
                         input logic [1:0] cls, input logic am, input logic la);
        @(posedge clk);
        #1;
        data_in = d; carry_in = ci; flags_in = fi; shift_op = op;
        bit_sel = b; op_class = cls; acc_mode = am; load_also = la;
        sb_q.push_back(model(d, ci, fi, op, b, cls, am, la));
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (data_out !== e.d || flags_out !== e.f || mem_we !== e.mw || reg_we !== e.rw) begin
                    errors++;
                    if (errors < 20)
                        $display("FAIL %s: got d=%h f=%h mw=%b rw=%b, expected d=%h f=%h mw=%b rw=%b",
                                 e.tag, data_out, flags_out, mem_we, reg_we, e.d, e.f, e.mw, e.rw);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle inputs after reset: rotate of zero gives zero with Z and P set (R1 R4)
        drive(8'h00, 1'b0, 8'h00, 3'd0, 3'd0, 2'b00, 1'b0, 1'b0);
        // R1 R2 R3 R4 R5: every shift kind, both carries, both flag modes
        for (int op = 0; op < 8; op++)
            for (int am = 0; am < 2; am++)
                for (int ci = 0; ci < 2; ci++)
                    for (int d = 0; d < 256; d++)
                        drive(8'(d), 1'(ci), 8'(d * 37 + op * 11 + ci * 90), 3'(op), 3'(d >> 5),
                              2'b00, 1'(am), 1'(d[0]));
        // R6 R7 R8 R9: test, reset, set on every bit index
        for (int cls = 1; cls < 4; cls++)
            for (int b = 0; b < 8; b++)
                for (int d = 0; d < 256; d++)
                    drive(8'(d), 1'(d[2]), 8'(d * 53 + b * 7 + cls), 3'(d), 3'(b),
                          2'(cls), 1'(d[1]), 1'(d[3]));
        wait (sb_q.size() == 0);
        @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule